// File: doc/BRIEF.md
# Digital Black Level Clamp Loop

This block closes the offset loop of an imaging front end. While the optical-black window is open, it compares each valid converter code against a programmable black target held in quarter-LSB units. The difference is integrated in a signed accumulator that carries extra fractional bits, which smooths pixel noise. The upper bits of the accumulator, together with the target, form a 10-bit correction word for an offset DAC ahead of the converter. A code above the target lowers the correction, and a code below it raises the correction. The correction carries over from line to line and is held between black windows.

The window strobe can be used active high or active low. When the loop is disabled, the accumulator freezes. The target still moves the correction as a static offset about its zero point, the code 128 (32 LSB).

Top module: `blk_clamp_loop`

## Requirements
- R1: A synchronous reset, `rst` high, clears the accumulator and sets `corr` to the mid-range code 512 whatever the other inputs are. With `target` = 128 and no update, `corr` stays at 512 after reset is released.
- R2: The accumulator changes only on a clock edge where `loop_en`, `pix_valid` and the window condition are all true. In any other cycle `corr` depends only on the held accumulator and on `target`.
- R3: The window condition is `blk_pulse == blk_pol`. With `blk_pol` = 1 the window is active while `blk_pulse` is high. With `blk_pol` = 0 it is active while `blk_pulse` is low.
- R4: The error of one update is `4*pix_code - target`, in quarter-LSB units. The accumulator is decreased by this error, so a code above the target lowers `corr` and a code equal to the target leaves it unchanged.
- R5: `corr` equals `512 + (acc >>> 4) + (target - 128)`, using an arithmetic (floor) shift. It is registered, so `corr` shows the new value one clock edge after the inputs that caused it.
- R6: With `loop_en` = 0 the accumulator is frozen, and a change of `target` by d moves `corr` by d, one edge later.
- R7: `corr` saturates to the range 0 to 1023 and never wraps at either rail.
- R8: The accumulator is clamped to the range -16384 to 16383. After driving it to the lower bound, 64 updates with error -255 followed by `target` = 255 give `corr` = 635.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_code | input | 10 | Converter output code |
| pix_valid | input | 1 | Marks `pix_code` as a valid pixel this cycle |
| blk_pulse | input | 1 | Optical-black window strobe |
| blk_pol | input | 1 | Window polarity: 1 active high, 0 active low |
| target | input | 8 | Black target in quarter-LSB units |
| loop_en | input | 1 | 1 runs the loop, 0 freezes it |
| corr | output | 10 | Offset DAC correction code |

## Verification
The bench builds the block with its default parameters: 10-bit codes, an 8-bit target, a 10-bit correction and 4 fractional bits. With these values the accumulator bound of 16384 is reached within about 65 full-scale updates, so both correction rails and the clamp on the accumulator are exercised in a short run. The small fractional shift also makes single-sample changes of one or two correction codes visible. This checks the sign of the error, the floor rounding of negative values and each window polarity.

// File: rtl/blk_clamp_loop.sv
module blk_clamp_loop #(
  parameter int CODE_W = 10,
  parameter int TGT_W  = 8,
  parameter int CORR_W = 10,
  parameter int FRAC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pix_code,
  input  logic              pix_valid,
  input  logic              blk_pulse,
  input  logic              blk_pol,
  input  logic [TGT_W-1:0]  target,
  input  logic              loop_en,
  output logic [CORR_W-1:0] corr
);
  localparam int AW = CORR_W + FRAC + 2;
  localparam int SW = AW + 2;
  localparam logic signed [SW-1:0] LIM_HI  = SW'((2 ** (CORR_W + FRAC)) - 1);
  localparam logic signed [SW-1:0] LIM_LO  = SW'(-(2 ** (CORR_W + FRAC)));
  localparam logic signed [SW-1:0] MID_S   = SW'(2 ** (CORR_W - 1));
  localparam logic signed [SW-1:0] REF_S   = SW'(2 ** (TGT_W - 1));
  localparam logic signed [SW-1:0] CMAX_S  = SW'((2 ** CORR_W) - 1);
  localparam logic [CORR_W-1:0]    MID_U   = CORR_W'(2 ** (CORR_W - 1));
  localparam logic [CORR_W-1:0]    CMAX_U  = CORR_W'((2 ** CORR_W) - 1);

  logic signed [AW-1:0] acc;
  logic signed [SW-1:0] code_q4, tgt_s, err, sum, acc_nxt, corr_raw;
  logic [CORR_W-1:0]    corr_sat;

  wire in_win = (blk_pulse == blk_pol);
  wire upd    = loop_en & pix_valid & in_win;

  assign code_q4 = $signed({{(SW - CODE_W - 2){1'b0}}, pix_code, 2'b00});
  assign tgt_s   = $signed({{(SW - TGT_W){1'b0}}, target});
  assign err     = code_q4 - tgt_s;
  assign sum     = SW'(acc) - err;

  always_comb begin
    if (!upd)              acc_nxt = SW'(acc);
    else if (sum > LIM_HI) acc_nxt = LIM_HI;
    else if (sum < LIM_LO) acc_nxt = LIM_LO;
    else                   acc_nxt = sum;
  end

  assign corr_raw = MID_S + (acc_nxt >>> FRAC) + tgt_s - REF_S;

  always_comb begin
    if (corr_raw < 0)           corr_sat = '0;
    else if (corr_raw > CMAX_S) corr_sat = CMAX_U;
    else                        corr_sat = corr_raw[CORR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      corr <= MID_U;
    end else begin
      acc  <= acc_nxt[AW-1:0];
      corr <= corr_sat;
    end
  end
endmodule

// File: rtl/blk_clamp_loop_chk.sv
module blk_clamp_loop_chk #(
  parameter int CODE_W = 10,
  parameter int TGT_W  = 8,
  parameter int CORR_W = 10,
  parameter int FRAC   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] pix_code,
  input logic              pix_valid,
  input logic              blk_pulse,
  input logic              blk_pol,
  input logic [TGT_W-1:0]  target,
  input logic              loop_en,
  input logic [CORR_W-1:0] corr
);
  localparam logic [CORR_W-1:0] MID_U  = CORR_W'(2 ** (CORR_W - 1));
  localparam logic [CORR_W-1:0] CMAX_U = CORR_W'((2 ** CORR_W) - 1);

  wire upd_c  = loop_en & pix_valid & (blk_pulse == blk_pol);
  wire err_hi = (int'(pix_code) * 4) > int'(target);
  wire err_lo = (int'(pix_code) * 4) < int'(target);

  AST_RESET_MID: assert property (@(posedge clk) rst |=> corr == MID_U); // R1

  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    (!upd_c && $stable(target) && !$past(rst)) |=> $stable(corr)); // R2

  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (loop_en && pix_valid && (blk_pulse != blk_pol) && $stable(target) && !$past(rst))
    |=> $stable(corr)); // R3

  AST_ERROR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (upd_c && err_hi && $stable(target) && !$past(rst)) |=> corr <= $past(corr)); // R4

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!loop_en && $stable(target) && !$past(rst)) |=> $stable(corr)); // R6

  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (rst)
    (upd_c && err_lo && $stable(target) && corr == CMAX_U && !$past(rst))
    |=> corr == CMAX_U); // R7

  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (rst)
    (upd_c && err_hi && $stable(target) && corr == '0 && !$past(rst))
    |=> corr == '0); // R7
endmodule

bind blk_clamp_loop blk_clamp_loop_chk #(
  .CODE_W(CODE_W), .TGT_W(TGT_W), .CORR_W(CORR_W), .FRAC(FRAC)
) u_chk (
  .clk(clk), .rst(rst), .pix_code(pix_code), .pix_valid(pix_valid),
  .blk_pulse(blk_pulse), .blk_pol(blk_pol), .target(target),
  .loop_en(loop_en), .corr(corr)
);

// File: tb/blk_clamp_loop_tb.sv
module blk_clamp_loop_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pix_code = '0;
  logic       pix_valid = 1'b0;
  logic       blk_pulse = 1'b0;
  logic       blk_pol = 1'b1;
  logic [7:0] target = 8'd200;
  logic       loop_en = 1'b1;
  logic [9:0] corr;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blk_clamp_loop u_dut (
    .clk(clk), .rst(rst), .pix_code(pix_code), .pix_valid(pix_valid),
    .blk_pulse(blk_pulse), .blk_pol(blk_pol), .target(target),
    .loop_en(loop_en), .corr(corr)
  );

  // {code, valid, blk, pol, en, target, expected corr}
  localparam int VN = 12;
  localparam logic [31:0] VEC [VN] = '{
    {10'd40,  1'b1, 1'b1, 1'b1, 1'b1, 8'd128, 10'd510}, // R4 code above target
    {10'd40,  1'b1, 1'b0, 1'b1, 1'b1, 8'd128, 10'd510}, // R3 window closed
    {10'd40,  1'b0, 1'b1, 1'b1, 1'b1, 8'd128, 10'd510}, // R2 invalid pixel
    {10'd28,  1'b1, 1'b1, 1'b1, 1'b1, 8'd128, 10'd511}, // R4 code below target
    {10'd32,  1'b1, 1'b0, 1'b0, 1'b1, 8'd128, 10'd511}, // R3 active low, zero error
    {10'd36,  1'b1, 1'b0, 1'b0, 1'b1, 8'd128, 10'd510}, // R3 active low update
    {10'd100, 1'b1, 1'b1, 1'b0, 1'b1, 8'd128, 10'd510}, // R3 active low, closed
    {10'd100, 1'b1, 1'b1, 1'b1, 1'b0, 8'd128, 10'd510}, // R6 frozen
    {10'd100, 1'b1, 1'b1, 1'b1, 1'b0, 8'd200, 10'd582}, // R6 static offset up
    {10'd100, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0,   10'd382}, // R6 static offset down
    {10'd0,   1'b1, 1'b1, 1'b1, 1'b1, 8'd0,   10'd382}, // R5 zero error
    {10'd0,   1'b1, 1'b1, 1'b1, 1'b1, 8'd255, 10'd652}  // R5 floor shift plus offset
  };

  task automatic check(input logic [9:0] exp, input string req);
    nvec++;
    if (corr !== exp) begin
      nfail++;
      $display("FAIL %s: corr=%0d expected=%0d", req, corr, exp);
    end
  endtask

  task automatic run(input int n, input logic [9:0] code, input logic [7:0] tgt);
    pix_code = code; target = tgt; pix_valid = 1'b1;
    blk_pol = 1'b1; blk_pulse = 1'b1; loop_en = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(10'd512, "R1");
    target = 8'd128;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(10'd512, "R1");

    for (int i = 0; i < VN; i++) begin
      {pix_code, pix_valid, blk_pulse, blk_pol, loop_en, target} = VEC[i][31:10];
      @(negedge clk);
      check(VEC[i][9:0], $sformatf("R%0d", (i == 7 || i == 8 || i == 9) ? 6 : 5));
    end

    run(100, 10'd0, 8'd255);
    check(10'd1023, "R7");
    run(100, 10'd0, 8'd255);
    check(10'd1023, "R7");
    run(20, 10'd1023, 8'd0);
    check(10'd0, "R7");
    run(3, 10'd32, 8'd128);
    check(10'd0, "R7");
    run(64, 10'd0, 8'd255);
    check(10'd635, "R8");

    rst = 1'b1; target = 8'd128; pix_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(10'd512, "R1");
    rst = 1'b0;
    @(negedge clk);
    check(10'd512, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: corr=%0d expected=finish", corr);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule